// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

When a small microcontroller core accepts an exception, it must save the caller's working registers to the active stack before the handler runs. This block does that save. A single start pulse hands it the current stack pointer, the two banked stack-alignment enables, the current security state, an ignore-fault control and the eight words to save. The block works out where the frame goes and writes the words one at a time. Every word is first sent to an external permission checker and is written to memory only when that check passes.

Any failure ends the save at once. A failure can be a security-attribution violation, a protection violation or an error response from memory. The block then records a sticky fault status bit whose meaning depends on the kind of failure. It also pulses a derived-exception pend request naming the exception type and its target bank, unless the ignore-fault control suppresses that request. In every case the block writes the frame base back as the new stack pointer and reports success or failure along with a one-cycle done pulse.

Top module: `stk_entry_seq`

## Requirements
- R1: On start the block latches its inputs. When bit 2 of `sp_in` is 1 and `align_en[sec_in]` is 1 (index 1 is the secure bank), the working pointer is `sp_in - 4`; otherwise it is `sp_in`. The frame base is the working pointer minus 0x20, computed modulo 2^ADDR_W.
- R2: The packed input `ctx_words` holds eight words. Slice i (`ctx_words[32*i +: 32]`) is word i, in the order r0, r1, r2, r3, r12, link register, return address, status. Word i goes to address base + 4*i, and the words are written in ascending order. Bit 9 of the status word is set when realignment occurred; its other bits are passed through unchanged.
- R3: Each word is offered on the check port (`chk_req` held high with `chk_addr`) before it is written. A write is issued only after a check response with code 0 (allowed). Code 1 means an attribution failure; codes 2 and 3 mean a protection failure. `chk_req` and `wr_valid` are never high together. `wr_valid` and `wr_addr` hold steady until `wr_ready` is seen, and only one write is outstanding at a time.
- R4: The first failed check or the first write response with `wr_rsp_err` = 1 ends the sequence. No later check or write is made after it.
- R5: An attribution failure raises SecureFault (`pend_exc` = 3, `pend_secure` = 0). It sets `sf_attr_viol` and `sf_addr_valid` and loads the faulting word address into `sf_addr`.
- R6: A protection failure raises MemManage (`pend_exc` = 1, `pend_secure` = latched security state). It sets `mm_stk_err[sec]`.
- R7: An error response on an allowed write raises BusFault (`pend_exc` = 2, `pend_secure` = 0). It sets `bus_stk_err`.
- R8: When `ignore_fault` is 1 at start, no pend pulse is produced after a fault, but the fault status outputs are still updated.
- R9: The end of a sequence gives a one-cycle `done` pulse. In the same cycle `sp_we` is 1 and `sp_wdata` equals the frame base, whether or not stacking succeeded. `fail` is 1 exactly when a fault ended the sequence. `pend_valid` can only be high together with `done` and `fail`.
- R10: A start pulse while a sequence is running is ignored. Fault status bits are sticky and are cleared only by reset.
- R11: After reset all request, pulse and status outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin stacking |
| sp_in | input | ADDR_W | Current stack pointer |
| align_en | input | 2 | Alignment enable per bank (1 = secure) |
| sec_in | input | 1 | Current security state |
| ignore_fault | input | 1 | Suppress derived-exception pend |
| ctx_words | input | 8*DATA_W | Words to save, word i at slice i |
| chk_req | output | 1 | Permission check request |
| chk_addr | output | ADDR_W | Address under check |
| chk_secure | output | 1 | Security state of the access |
| chk_rsp_valid | input | 1 | Check response strobe |
| chk_rsp_code | input | 2 | 0 ok, 1 attribution fail, 2/3 protection fail |
| wr_valid | output | 1 | Memory write request |
| wr_ready | input | 1 | Write request accepted |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | DATA_W | Write data |
| wr_rsp_valid | input | 1 | Write response strobe |
| wr_rsp_err | input | 1 | Write response is an error |
| sp_we | output | 1 | Stack pointer write strobe |
| sp_wdata | output | ADDR_W | New stack pointer |
| done | output | 1 | Sequence finished |
| fail | output | 1 | Stacking failed |
| pend_valid | output | 1 | Derived exception pend pulse |
| pend_exc | output | 2 | 1 MemManage, 2 BusFault, 3 SecureFault |
| pend_secure | output | 1 | Target bank of the pend |
| sf_attr_viol | output | 1 | Secure fault attribution violation |
| sf_addr_valid | output | 1 | Secure fault address valid |
| sf_addr | output | ADDR_W | Secure fault address |
| mm_stk_err | output | 2 | MemManage stacking error per bank |
| bus_stk_err | output | 1 | BusFault stacking error |

## Verification
The bench builds the block with ADDR_W = 16 and DATA_W = 32. The narrow address makes wrap-around of the frame base below zero easy to reach: a stack pointer of 0x0004 gives a base of 0xFFE0, and random pointers often land where bit 2 and the alignment enables interact. Random fault positions across all eight words, together with random handshake latencies, exercise faults at the first and last word and the holding of requests while the responder stalls.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int FRAME_WORDS = 8;

  typedef enum logic [1:0] {
    EXC_NONE        = 2'd0,
    EXC_MEMMANAGE   = 2'd1,
    EXC_BUSFAULT    = 2'd2,
    EXC_SECUREFAULT = 2'd3
  } exc_e;

  localparam logic [1:0] CHK_OK   = 2'd0;
  localparam logic [1:0] CHK_ATTR = 2'd1;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CHECK,
    S_WRITE,
    S_RESP
  } seq_state_e;
endpackage

// File: rtl/stk_frame_calc.sv
module stk_frame_calc #(
  parameter int AW          = 32,
  parameter int DW          = 32,
  parameter int NW          = 8,
  parameter int ALIGN_BIT   = 2,
  parameter int REALIGN_BIT = 9
) (
  input  logic [AW-1:0] sp,
  input  logic          align_en,
  input  logic [DW-1:0] status_in,
  output logic [AW-1:0] base,
  output logic [DW-1:0] status_out
);
  localparam int WORD_BYTES = DW / 8;
  localparam logic [AW-1:0] STEP        = AW'(1 << ALIGN_BIT);
  localparam logic [AW-1:0] FRAME_BYTES = AW'(NW * WORD_BYTES);

  logic          realign;
  logic [AW-1:0] ptr;

  always_comb begin
    realign    = sp[ALIGN_BIT] & align_en;
    ptr        = realign ? (sp - STEP) : sp;
    base       = ptr - FRAME_BYTES;
    status_out = status_in | (DW'(realign) << REALIGN_BIT);
  end
endmodule

// File: rtl/stk_word_sel.sv
module stk_word_sel #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int NW = 8,
  localparam int IW = $clog2(NW)
) (
  input  logic [NW*DW-1:0] words,
  input  logic [IW-1:0]    idx,
  input  logic [AW-1:0]    base,
  output logic [DW-1:0]    data,
  output logic [AW-1:0]    addr
);
  localparam int WORD_BYTES = DW / 8;

  logic [DW-1:0] slot [NW];

  for (genvar g = 0; g < NW; g++) begin : g_slot
    assign slot[g] = words[g*DW +: DW];
  end

  assign data = slot[idx];
  assign addr = base + AW'(idx) * AW'(WORD_BYTES);
endmodule

// File: rtl/stk_fault_log.sv
module stk_fault_log
  import stk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev,
  input  exc_e          kind,
  input  logic          secure,
  input  logic [AW-1:0] addr,
  output logic          attr_viol,
  output logic          addr_valid,
  output logic [AW-1:0] fault_addr,
  output logic [1:0]    mm_err,
  output logic          bus_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      attr_viol  <= 1'b0;
      addr_valid <= 1'b0;
      fault_addr <= '0;
      mm_err     <= '0;
      bus_err    <= 1'b0;
    end else if (ev) begin
      unique case (kind)
        EXC_SECUREFAULT: begin
          attr_viol  <= 1'b1;
          addr_valid <= 1'b1;
          fault_addr <= addr;
        end
        EXC_MEMMANAGE: mm_err[secure] <= 1'b1;
        EXC_BUSFAULT:  bus_err        <= 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stk_entry_seq.sv
module stk_entry_seq
  import stk_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int ALIGN_BIT   = 2,
  parameter int REALIGN_BIT = 9
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         sp_in,
  input  logic [1:0]                align_en,
  input  logic                      sec_in,
  input  logic                      ignore_fault,
  input  logic [8*DATA_W-1:0]       ctx_words,
  output logic                      chk_req,
  output logic [ADDR_W-1:0]         chk_addr,
  output logic                      chk_secure,
  input  logic                      chk_rsp_valid,
  input  logic [1:0]                chk_rsp_code,
  output logic                      wr_valid,
  input  logic                      wr_ready,
  output logic [ADDR_W-1:0]         wr_addr,
  output logic [DATA_W-1:0]         wr_data,
  input  logic                      wr_rsp_valid,
  input  logic                      wr_rsp_err,
  output logic                      sp_we,
  output logic [ADDR_W-1:0]         sp_wdata,
  output logic                      done,
  output logic                      fail,
  output logic                      pend_valid,
  output logic [1:0]                pend_exc,
  output logic                      pend_secure,
  output logic                      sf_attr_viol,
  output logic                      sf_addr_valid,
  output logic [ADDR_W-1:0]         sf_addr,
  output logic [1:0]                mm_stk_err,
  output logic                      bus_stk_err
);
  localparam int NW = FRAME_WORDS;
  localparam int IW = $clog2(NW);
  localparam logic [IW-1:0] LAST = IW'(NW - 1);

  seq_state_e          state;
  logic [IW-1:0]       idx;
  logic [ADDR_W-1:0]   base_q;
  logic [NW*DATA_W-1:0] words_q;
  logic                sec_q;
  logic                ign_q;

  logic [ADDR_W-1:0]   base_d;
  logic [DATA_W-1:0]   status_d;
  logic [ADDR_W-1:0]   cur_addr;
  logic [DATA_W-1:0]   cur_data;

  logic                fault_ev;
  exc_e                fault_kind;
  logic                finish_ok;

  stk_frame_calc #(
    .AW(ADDR_W), .DW(DATA_W), .NW(NW),
    .ALIGN_BIT(ALIGN_BIT), .REALIGN_BIT(REALIGN_BIT)
  ) u_calc (
    .sp        (sp_in),
    .align_en  (align_en[sec_in]),
    .status_in (ctx_words[(NW-1)*DATA_W +: DATA_W]),
    .base      (base_d),
    .status_out(status_d)
  );

  stk_word_sel #(.AW(ADDR_W), .DW(DATA_W), .NW(NW)) u_sel (
    .words(words_q),
    .idx  (idx),
    .base (base_q),
    .data (cur_data),
    .addr (cur_addr)
  );

  always_comb begin
    fault_ev   = 1'b0;
    fault_kind = EXC_NONE;
    finish_ok  = 1'b0;
    if (state == S_CHECK && chk_rsp_valid && chk_rsp_code != CHK_OK) begin
      fault_ev   = 1'b1;
      fault_kind = (chk_rsp_code == CHK_ATTR) ? EXC_SECUREFAULT : EXC_MEMMANAGE;
    end else if (state == S_RESP && wr_rsp_valid) begin
      if (wr_rsp_err) begin
        fault_ev   = 1'b1;
        fault_kind = EXC_BUSFAULT;
      end else if (idx == LAST) begin
        finish_ok = 1'b1;
      end
    end
  end

  stk_fault_log #(.AW(ADDR_W)) u_log (
    .clk       (clk),
    .rst       (rst),
    .ev        (fault_ev),
    .kind      (fault_kind),
    .secure    (sec_q),
    .addr      (cur_addr),
    .attr_viol (sf_attr_viol),
    .addr_valid(sf_addr_valid),
    .fault_addr(sf_addr),
    .mm_err    (mm_stk_err),
    .bus_err   (bus_stk_err)
  );

  assign chk_addr   = cur_addr;
  assign wr_addr    = cur_addr;
  assign wr_data    = cur_data;
  assign chk_secure = sec_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      idx         <= '0;
      base_q      <= '0;
      words_q     <= '0;
      sec_q       <= 1'b0;
      ign_q       <= 1'b0;
      chk_req     <= 1'b0;
      wr_valid    <= 1'b0;
      sp_we       <= 1'b0;
      sp_wdata    <= '0;
      done        <= 1'b0;
      fail        <= 1'b0;
      pend_valid  <= 1'b0;
      pend_exc    <= 2'd0;
      pend_secure <= 1'b0;
    end else begin
      done       <= 1'b0;
      sp_we      <= 1'b0;
      pend_valid <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (start) begin
            base_q  <= base_d;
            words_q <= {status_d, ctx_words[(NW-1)*DATA_W-1:0]};
            sec_q   <= sec_in;
            ign_q   <= ignore_fault;
            idx     <= '0;
            chk_req <= 1'b1;
            state   <= S_CHECK;
          end
        end
        S_CHECK: begin
          if (chk_rsp_valid) begin
            chk_req <= 1'b0;
            if (!fault_ev) begin
              wr_valid <= 1'b1;
              state    <= S_WRITE;
            end
          end
        end
        S_WRITE: begin
          if (wr_ready) begin
            wr_valid <= 1'b0;
            state    <= S_RESP;
          end
        end
        S_RESP: begin
          if (wr_rsp_valid && !fault_ev && !finish_ok) begin
            idx     <= idx + 1'b1;
            chk_req <= 1'b1;
            state   <= S_CHECK;
          end
        end
        default: state <= S_IDLE;
      endcase

      if (fault_ev || finish_ok) begin
        state       <= S_IDLE;
        done        <= 1'b1;
        sp_we       <= 1'b1;
        sp_wdata    <= base_q;
        fail        <= fault_ev;
        pend_valid  <= fault_ev & ~ign_q;
        pend_exc    <= fault_kind;
        pend_secure <= (fault_kind == EXC_MEMMANAGE) ? sec_q : 1'b0;
      end
    end
  end
endmodule

// File: rtl/stk_entry_chk.sv
module stk_entry_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          done,
  input logic          fail,
  input logic          sp_we,
  input logic          pend_valid,
  input logic [1:0]    pend_exc,
  input logic          pend_secure,
  input logic          chk_req,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [AW-1:0] wr_addr,
  input logic          bus_stk_err,
  input logic          sf_attr_viol,
  input logic          sf_addr_valid
);
  // R3
  req_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(chk_req && wr_valid));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr));

  // R9
  done_sp_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> sp_we);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  pend_with_fail_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid |-> done && fail);

  // R5
  secure_fault_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid && pend_exc == 2'd3 |-> !pend_secure && sf_attr_viol && sf_addr_valid);

  // R7
  bus_fault_chk: assert property (@(posedge clk) disable iff (rst)
    pend_valid && pend_exc == 2'd2 |-> !pend_secure && bus_stk_err);
endmodule

bind stk_entry_seq stk_entry_chk #(.AW(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .done         (done),
  .fail         (fail),
  .sp_we        (sp_we),
  .pend_valid   (pend_valid),
  .pend_exc     (pend_exc),
  .pend_secure  (pend_secure),
  .chk_req      (chk_req),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .bus_stk_err  (bus_stk_err),
  .sf_attr_viol (sf_attr_viol),
  .sf_addr_valid(sf_addr_valid)
);

// File: tb/sim_stk_entry_seq.sv
module sim_stk_entry_seq;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          start;
  logic [AW-1:0] sp_in;
  logic [1:0]    align_en;
  logic          sec_in;
  logic          ignore_fault;
  logic [8*DW-1:0] ctx_words;
  logic          chk_req;
  logic [AW-1:0] chk_addr;
  logic          chk_secure;
  logic          chk_rsp_valid;
  logic [1:0]    chk_rsp_code;
  logic          wr_valid;
  logic          wr_ready;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic          wr_rsp_valid;
  logic          wr_rsp_err;
  logic          sp_we;
  logic [AW-1:0] sp_wdata;
  logic          done;
  logic          fail;
  logic          pend_valid;
  logic [1:0]    pend_exc;
  logic          pend_secure;
  logic          sf_attr_viol;
  logic          sf_addr_valid;
  logic [AW-1:0] sf_addr;
  logic [1:0]    mm_stk_err;
  logic          bus_stk_err;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  logic          m_attr, m_av, m_bus;
  logic [1:0]    m_mm;
  logic [AW-1:0] m_addr;

  stk_entry_seq #(.ADDR_W(AW), .DATA_W(DW)) u0 (.*);

  always #5 clk = ~clk;

  task automatic check(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  function automatic logic [AW-1:0] exp_base(input logic [AW-1:0] sp, input logic [1:0] al,
                                             input logic sec);
    logic ra = sp[2] & al[sec];
    return (ra ? sp - 16'd4 : sp) - 16'h20;
  endfunction

  function automatic logic [DW-1:0] exp_word(input logic [8*DW-1:0] w, input int k,
                                             input logic [AW-1:0] sp, input logic [1:0] al,
                                             input logic sec);
    logic [DW-1:0] v = w[k*DW +: DW];
    if (k == 7 && sp[2] && al[sec]) v = v | 32'h200;
    return v;
  endfunction

  task automatic rand_delay();
    int d = $urandom % 3;
    for (int i = 0; i < d; i++) @(negedge clk);
  endtask

  task automatic wait_hi(input int which);
    for (int i = 0; i < 40; i++) begin
      if ((which == 0 && chk_req) || (which == 1 && wr_valid) || (which == 2 && done)) return;
      @(negedge clk);
    end
  endtask

  // fault_at 0..7 selects the failing word, 8 means no fault;
  // kind 1 attribution, 2 protection, 3 write error
  task automatic run_case(input logic [AW-1:0] sp, input logic [1:0] al, input logic sec,
                          input logic ign, input logic [8*DW-1:0] w, input int fault_at,
                          input int kind, input logic busy_start);
    logic [AW-1:0] base = exp_base(sp, al, sec);
    int writes = 0;
    logic faulted = 1'b0;
    @(negedge clk);
    sp_in = sp; align_en = al; sec_in = sec; ignore_fault = ign; ctx_words = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    sp_in = 16'($urandom); ctx_words = {8{$urandom}}; sec_in = ~sec; ignore_fault = ~ign;
    for (int k = 0; k < 8; k++) begin
      wait_hi(0);
      // R3 each word checked first, at its own address
      check(chk_req && !wr_valid && chk_addr == base + 16'(4*k) && chk_secure == sec,
            "R3 check request", 32'(chk_addr), 32'(base + 16'(4*k)));
      if (busy_start && k == 1) begin
        // R10 start while busy
        start = 1'b1; sp_in = 16'($urandom);
        @(negedge clk);
        start = 1'b0;
      end
      rand_delay();
      chk_rsp_valid = 1'b1;
      chk_rsp_code  = (k == fault_at && kind != 3) ? 2'(kind) : 2'd0;
      if (k == fault_at && kind == 2 && ($urandom % 2 == 1)) chk_rsp_code = 2'd3;
      @(negedge clk);
      chk_rsp_valid = 1'b0;
      if (k == fault_at && kind != 3) begin
        faulted = 1'b1;
        if (kind == 1) begin m_attr = 1'b1; m_av = 1'b1; m_addr = base + 16'(4*k); end
        else m_mm[sec] = 1'b1;
        break;
      end
      wait_hi(1);
      // R1 R2 address and data of word k
      check(wr_valid && wr_addr == base + 16'(4*k), "R1 write address",
            32'(wr_addr), 32'(base + 16'(4*k)));
      check(wr_data == exp_word(w, k, sp, al, sec), "R2 write data", wr_data,
            exp_word(w, k, sp, al, sec));
      rand_delay();
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
      writes++;
      rand_delay();
      wr_rsp_valid = 1'b1;
      wr_rsp_err   = (k == fault_at && kind == 3);
      @(negedge clk);
      wr_rsp_valid = 1'b0;
      wr_rsp_err   = 1'b0;
      if (k == fault_at && kind == 3) begin
        faulted = 1'b1; m_bus = 1'b1;
        break;
      end
    end
    wait_hi(2);
    check(done && sp_we && sp_wdata == base, "R9 done with stack pointer write",
          32'(sp_wdata), 32'(base));
    check(fail == faulted, "R9 fail flag", 32'(fail), 32'(faulted));
    check(pend_valid == (faulted && !ign), "R8 pend request", 32'(pend_valid),
          32'(faulted && !ign));
    if (faulted && !ign) begin
      logic [1:0] ex = (kind == 1) ? 2'd3 : (kind == 2) ? 2'd1 : 2'd2;
      logic       es = (kind == 2) ? sec : 1'b0;
      check(pend_exc == ex, kind == 1 ? "R5 pend type" : kind == 2 ? "R6 pend type" : "R7 pend type",
            32'(pend_exc), 32'(ex));
      check(pend_secure == es, "R6 pend bank", 32'(pend_secure), 32'(es));
    end
    check({sf_attr_viol, sf_addr_valid, sf_addr} == {m_attr, m_av, m_addr},
          "R5 secure fault status", 32'({sf_attr_viol, sf_addr_valid, sf_addr}),
          32'({m_attr, m_av, m_addr}));
    check(mm_stk_err == m_mm, "R6 MemManage status", 32'(mm_stk_err), 32'(m_mm));
    check(bus_stk_err == m_bus, "R7 BusFault status", 32'(bus_stk_err), 32'(m_bus));
    check(writes == (faulted ? (kind == 3 ? fault_at + 1 : fault_at) : 8), "R4 write count",
          32'(writes), 32'(faulted ? (kind == 3 ? fault_at + 1 : fault_at) : 8));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!done && !chk_req && !wr_valid, "R4 idle after end", 32'({done, chk_req, wr_valid}), 0);
    end
  endtask

  initial begin
    int unsigned sd = $urandom(32'd7731);
    rst = 1'b1; start = 1'b0; sp_in = '0; align_en = '0; sec_in = 1'b0; ignore_fault = 1'b0;
    ctx_words = '0; chk_rsp_valid = 1'b0; chk_rsp_code = '0; wr_ready = 1'b0;
    wr_rsp_valid = 1'b0; wr_rsp_err = 1'b0;
    m_attr = 1'b0; m_av = 1'b0; m_bus = 1'b0; m_mm = '0; m_addr = '0;
    if (sd == 32'hFFFF_FFFF) $display("seed");
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11
    check({chk_req, wr_valid, done, sp_we, fail, pend_valid} == 6'b0, "R11 reset outputs",
          32'({chk_req, wr_valid, done, sp_we, fail, pend_valid}), 0);
    check({sf_attr_viol, sf_addr_valid, mm_stk_err, bus_stk_err} == 5'b0, "R11 reset status",
          32'({sf_attr_viol, sf_addr_valid, mm_stk_err, bus_stk_err}), 0);

    // directed corner cases
    run_case(16'h8000, 2'b11, 1'b0, 1'b0, {8{32'h1111_0000}} ^ 256'h7, 8, 0, 1'b0); // R1 no realign
    run_case(16'h8004, 2'b01, 1'b0, 1'b0, {8{32'hA5A5_0F0F}}, 8, 0, 1'b0);          // R1 R2 realign
    run_case(16'h8004, 2'b01, 1'b1, 1'b0, {8{32'h0000_0100}}, 8, 0, 1'b1);          // R1 other bank, R10
    run_case(16'h0004, 2'b11, 1'b1, 1'b0, {8{32'h1234_5678}}, 8, 0, 1'b0);          // R1 wrap
    run_case(16'h4000, 2'b00, 1'b1, 1'b0, {8{32'hDEAD_BEEF}}, 0, 1, 1'b0);          // R5 first word
    run_case(16'h4010, 2'b11, 1'b1, 1'b0, {8{32'hCAFE_0001}}, 0, 2, 1'b0);          // R6 secure bank
    run_case(16'h4010, 2'b11, 1'b0, 1'b1, {8{32'hCAFE_0002}}, 3, 2, 1'b0);          // R8 ignored pend
    run_case(16'h2000, 2'b10, 1'b0, 1'b0, {8{32'hBEEF_0003}}, 7, 3, 1'b0);          // R7 last word

    for (int n = 0; n < 60; n++) begin
      logic [8*DW-1:0] w;
      for (int i = 0; i < 8; i++) w[i*DW +: DW] = $urandom;
      run_case(16'($urandom) & 16'hFFFC, 2'($urandom), 1'($urandom), 1'($urandom), w,
               int'($urandom % 10), int'($urandom % 3) + 1, 1'($urandom));
    end
    summary();
  end
endmodule